// File: doc/BRIEF.md
# Double-Buffered Serial Transceiver with Interrupt Flags

This block is an asynchronous serial transceiver for 8 data bits, no parity and one stop bit. A one-byte holding register feeds the transmit shift register, and a receive data register sits behind the receive shift register. Software can therefore write the next byte, or collect the last received byte, while the shifter is still busy with the current one. The bit rate is fixed by a parameter. Each bit lasts 16 ticks of an internal oversampling clock, and one tick is `CLKS_PER_TICK` system clocks.

A status unit keeps five flags: receive-full, transmit-empty, transmit-end, overrun and framing error. It drives three interrupt lines. Each line is high while its flag and the matching enable bit are both 1. Transmit-end is kept apart from transmit-empty. Transmit-empty says the holding register can take another byte. Transmit-end says the line has gone idle, because the last stop bit has left the shifter and nothing was waiting behind it.

The bus side is a 2-bit address with a write strobe. Reads are combinational and have no side effects. Address 0 is the transmit holding register (write). Address 1 is the receive data register (read). Address 2 is status (read, write 1 to clear). Address 3 is the interrupt enables (read and write).

Top module: `dbuf_uart`

## Requirements
- R1: After reset, status (address 2) reads 0x06: bit 1 transmit-empty = 1, bit 2 transmit-end = 1, and bit 0 receive-full, bit 3 overrun and bit 4 framing error all 0. The enable register (address 3) reads 0, `txd` is 1 and all three interrupt outputs are 0.
- R2: A byte written to address 0 while the transmitter is idle goes out on `txd` as one low start bit, then the 8 data bits least significant first, then one high stop bit. Each bit lasts 16*`CLKS_PER_TICK` clocks.
- R3: A write to address 0 clears transmit-empty (status bit 1) on the next clock edge. The flag returns to 1 when the held byte moves into the shifter. Writing 1 to status bit 1 has no effect. `irq_tx_empty` equals status bit 1 AND enable bit 1.
- R4: A byte that is waiting in the holding register when a stop bit ends begins its start bit on the very next clock, with no idle time on the line.
- R5: Transmit-end (status bit 2) is set when a stop bit finishes while transmit-empty is 1. A write to address 0 clears it, and so does writing 1 to status bit 2. It stays 0 while a byte is pending or in flight. `irq_tx_end` equals status bit 2 AND enable bit 2.
- R6: A character whose stop bit samples high is copied into the receive data register (address 1) and sets receive-full (status bit 0), provided receive-full was 0. `irq_rx_full` equals status bit 0 AND enable bit 0.
- R7: Writing 1 to status bit 0 clears receive-full, so the next character is accepted. The enable register reads back the value last written to its bits 2:0.
- R8: A good character that completes while receive-full is 1 sets overrun (status bit 3) and leaves the receive data register unchanged.
- R9: A character whose stop bit samples low sets framing error (status bit 4). The character is not transferred and receive-full does not change. Writing 1 to bit 4 clears the flag.
- R10: A low pulse on `rxd` that has ended before the middle of the start bit produces no character and no flag. The receiver then accepts the next real character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq_rx_full | output | 1 | Receive-full interrupt |
| irq_tx_empty | output | 1 | Transmit-empty interrupt |
| irq_tx_end | output | 1 | Transmit-end interrupt |

## Verification
The bench queues a second and a third byte so that each is waiting when the previous stop bit ends. It measures the idle time before each following start bit, and a design that waited one extra clock or one bit time before reloading the shifter fails on that gap. It reads transmit-end while a byte is pending and again after the line goes idle. This catches a design that merges transmit-end with transmit-empty, or that never clears it on a data write. On the receive side it lets a second good character arrive before clearing receive-full, sends a character with a low stop bit, and pulses the line low for a quarter bit. A receiver that overwrote held data, transferred a broken character, or took the glitch as a start bit would show the wrong data or flags at address 1 and address 2.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int unsigned OVS        = 16;
  localparam int unsigned HALF_OVS   = OVS / 2;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;
  localparam int unsigned NUM_IRQ    = 3;

  typedef enum logic [1:0] {
    REG_TXHOLD = 2'd0,
    REG_RXDATA = 2'd1,
    REG_STATUS = 2'd2,
    REG_CTRL   = 2'd3
  } reg_addr_e;

  // bit 0 rx_full, 1 tx_empty, 2 tx_end, 3 overrun, 4 framing
  typedef struct packed {
    logic ferr;
    logic ovr;
    logic tx_end;
    logic tx_empty;
    logic rx_full;
  } status_t;

  // serialized frame, bit 0 leaves the line first
  function automatic logic [FRAME_BITS-1:0] frame_of(input logic [DATA_BITS-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  function automatic logic irq_of(input logic flag, input logic en);
    return flag & en;
  endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; #(
  parameter int unsigned CLKS_PER_TICK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  output logic                 ready,
  output logic                 frame_end,
  output logic                 txd
);
  localparam int unsigned TCW = $clog2(OVS);
  localparam int unsigned BCW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic                  busy_q;
  logic [TCW-1:0]        tcnt_q;
  logic [BCW-1:0]        bit_q;
  logic                  tick;

  uart_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick)
  );

  assign frame_end = busy_q && tick && (tcnt_q == TCW'(OVS - 1))
                     && (bit_q == BCW'(FRAME_BITS - 1));
  assign ready     = !busy_q || frame_end;
  assign txd       = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      busy_q <= 1'b0;
      tcnt_q <= '0;
      bit_q  <= '0;
    end else if (load) begin
      sh_q   <= frame_of(data);
      busy_q <= 1'b1;
      tcnt_q <= '0;
      bit_q  <= '0;
    end else if (busy_q && tick) begin
      if (tcnt_q == TCW'(OVS - 1)) begin
        tcnt_q <= '0;
        if (bit_q == BCW'(FRAME_BITS - 1)) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; #(
  parameter int unsigned CLKS_PER_TICK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  output logic                 done,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 stop_ok
);
  localparam int unsigned TCW = $clog2(OVS);
  localparam int unsigned BCW = $clog2(DATA_BITS);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;

  rx_state_e            state_q;
  logic [1:0]           sync_q;
  logic                 line;
  logic                 tick;
  logic                 restart;
  logic [TCW-1:0]       tcnt_q;
  logic [BCW-1:0]       bit_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 done_q;
  logic                 stop_q;

  assign line    = sync_q[1];
  assign restart = (state_q == RX_IDLE) && !line;

  uart_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (!line) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt_q == TCW'(HALF_OVS - 1)) begin
              tcnt_q <= '0;
              bit_q  <= '0;
              state_q <= line ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (tcnt_q == TCW'(OVS - 1)) begin
              tcnt_q <= '0;
              sh_q   <= {line, sh_q[DATA_BITS-1:1]};
              if (bit_q == BCW'(DATA_BITS - 1)) state_q <= RX_STOP;
              else                              bit_q   <= bit_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (tcnt_q == TCW'(OVS - 1)) begin
              tcnt_q  <= '0;
              done_q  <= 1'b1;
              stop_q  <= line;
              state_q <= line ? RX_IDLE : RX_HOLD;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (line) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign byte_o  = sh_q;
  assign stop_ok = stop_q;
endmodule

// File: rtl/uart_regs.sv
module uart_regs import uart_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic                 rx_done,
  input  logic [DATA_BITS-1:0] rx_byte,
  input  logic                 rx_stop_ok,
  input  logic                 tx_ready,
  input  logic                 tx_frame_end,
  output logic                 tx_load,
  output logic                 hold_wr,
  output logic [DATA_BITS-1:0] hold_data,
  output logic [DATA_BITS-1:0] rx_data,
  output status_t              status,
  output logic [NUM_IRQ-1:0]   irq
);
  status_t              st_q;
  status_t              clr;
  logic [NUM_IRQ-1:0]   ctrl_q;
  logic [NUM_IRQ-1:0]   flag_vec;
  logic [DATA_BITS-1:0] hold_q;
  logic [DATA_BITS-1:0] rxd_q;
  logic                 wr, st_wr, ctrl_wr;
  logic                 rx_good, rx_accept, rx_overrun, rx_bad, end_set;

  assign wr      = bus_sel && bus_we;
  assign hold_wr = wr && (reg_addr_e'(bus_addr) == REG_TXHOLD);
  assign st_wr   = wr && (reg_addr_e'(bus_addr) == REG_STATUS);
  assign ctrl_wr = wr && (reg_addr_e'(bus_addr) == REG_CTRL);
  assign clr     = st_wr ? status_t'(bus_wdata[4:0]) : '0;

  assign rx_good    = rx_done && rx_stop_ok;
  assign rx_accept  = rx_good && !st_q.rx_full;
  assign rx_overrun = rx_good && st_q.rx_full;
  assign rx_bad     = rx_done && !rx_stop_ok;
  assign tx_load    = tx_ready && !st_q.tx_empty;
  assign end_set    = tx_frame_end && st_q.tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '{ferr: 1'b0, ovr: 1'b0, tx_end: 1'b1, tx_empty: 1'b1, rx_full: 1'b0};
      ctrl_q <= '0;
      hold_q <= '0;
      rxd_q  <= '0;
    end else begin
      st_q.rx_full  <= rx_accept  ? 1'b1 : (clr.rx_full ? 1'b0 : st_q.rx_full);
      st_q.tx_empty <= hold_wr    ? 1'b0 : (tx_load ? 1'b1 : st_q.tx_empty);
      st_q.tx_end   <= hold_wr    ? 1'b0 : (end_set ? 1'b1 : (clr.tx_end ? 1'b0 : st_q.tx_end));
      st_q.ovr      <= rx_overrun ? 1'b1 : (clr.ovr ? 1'b0 : st_q.ovr);
      st_q.ferr     <= rx_bad     ? 1'b1 : (clr.ferr ? 1'b0 : st_q.ferr);
      if (ctrl_wr)   ctrl_q <= bus_wdata[NUM_IRQ-1:0];
      if (hold_wr)   hold_q <= bus_wdata;
      if (rx_accept) rxd_q  <= rx_byte;
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      REG_RXDATA: bus_rdata = rxd_q;
      REG_STATUS: bus_rdata = {3'b000, st_q};
      REG_CTRL:   bus_rdata = {{(8-NUM_IRQ){1'b0}}, ctrl_q};
      default:    bus_rdata = 8'h00;
    endcase
  end

  assign flag_vec = {st_q.tx_end, st_q.tx_empty, st_q.rx_full};

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    assign irq[g] = irq_of(flag_vec[g], ctrl_q[g]);
  end

  assign hold_data = hold_q;
  assign rx_data   = rxd_q;
  assign status    = st_q;
endmodule

// File: rtl/dbuf_uart.sv
module dbuf_uart import uart_pkg::*; #(
  parameter int unsigned CLKS_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq_rx_full,
  output logic       irq_tx_empty,
  output logic       irq_tx_end
);
  logic                 tx_ready;
  logic                 tx_load;
  logic                 tx_frame_end;
  logic                 hold_wr;
  logic [DATA_BITS-1:0] hold_data;
  logic                 rx_done;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 rx_stop_ok;
  logic [DATA_BITS-1:0] rx_data;
  status_t              status;
  logic [NUM_IRQ-1:0]   irq;

  uart_tx #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .data(hold_data),
    .ready(tx_ready), .frame_end(tx_frame_end), .txd(txd)
  );

  uart_rx #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .done(rx_done), .byte_o(rx_byte), .stop_ok(rx_stop_ok)
  );

  uart_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .rx_byte(rx_byte), .rx_stop_ok(rx_stop_ok),
    .tx_ready(tx_ready), .tx_frame_end(tx_frame_end),
    .tx_load(tx_load), .hold_wr(hold_wr), .hold_data(hold_data),
    .rx_data(rx_data), .status(status), .irq(irq)
  );

  assign irq_rx_full  = irq[0];
  assign irq_tx_empty = irq[1];
  assign irq_tx_end   = irq[2];
endmodule

// File: rtl/uart_chk.sv
module uart_chk import uart_pkg::*; (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_done,
  input logic                 rx_stop_ok,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 tx_load,
  input logic                 tx_frame_end,
  input logic                 hold_wr,
  input logic                 txd,
  input status_t              stat
);
  // R6: a good character with the register free is taken over
  a_r6_accept_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_stop_ok && !stat.rx_full |=> stat.rx_full && rx_data == $past(rx_byte));

  // R8: a character arriving over a full register leaves it alone
  a_r8_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_stop_ok && stat.rx_full |=> stat.ovr && $stable(rx_data));

  // R9: a low stop bit flags and discards
  a_r9_framing_discards: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_stop_ok |=> stat.ferr && $stable(rx_data));

  // R3: a data write empties nothing and a move refills the flag
  a_r3_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !stat.tx_empty);
  a_r3_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !hold_wr |=> stat.tx_empty);

  // R4: a waiting byte starts right after the stop bit
  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_end && !stat.tx_empty |=> !txd);

  // R5: transmit-end follows an unreloaded stop bit and means an idle line
  a_r5_end_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_end && stat.tx_empty && !hold_wr |=> stat.tx_end);
  a_r5_end_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stat.tx_end |-> txd);
endmodule

bind dbuf_uart uart_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_done(rx_done), .rx_stop_ok(rx_stop_ok), .rx_byte(rx_byte), .rx_data(rx_data),
  .tx_load(tx_load), .tx_frame_end(tx_frame_end), .hold_wr(hold_wr),
  .txd(txd), .stat(status)
);

// File: tb/dbuf_uart_tb.sv
module dbuf_uart_tb;
  localparam int CPT      = 4;
  localparam int BIT_CLKS = 16 * CPT;
  localparam logic [1:0] A_HOLD = 2'd0, A_RX = 2'd1, A_ST = 2'd2, A_EN = 2'd3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, bus_sel, bus_we, rxd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  wire  [7:0] bus_rdata;
  wire        txd, irq_rx_full, irq_tx_empty, irq_tx_end;

  dbuf_uart #(.CLKS_PER_TICK(CPT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq_rx_full(irq_rx_full),
    .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end)
  );

  int n_checks = 0;
  int n_err    = 0;
  logic [8:0] exp_q[$];   // {follows_without_gap, data}
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_status(input int pos, input logic val, input int limit, output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      bus_read(A_ST, s);
      if (s[pos] == val) begin ok = 1; break; end
    end
  endtask

  task automatic send_tx(input logic [7:0] d, input bit adjacent);
    exp_q.push_back({adjacent, d});
    bus_write(A_HOLD, d);
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // monitor: decodes txd and scores it against the queue
  initial begin : tx_mon
    int gap;
    logic [7:0] got;
    logic [8:0] item;
    gap = 1000000;
    forever begin
      @(negedge clk);
      if (gap < 1000000) gap++;
      if (txd === 1'b0) begin
        repeat (BIT_CLKS / 2) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CLKS) @(negedge clk);
          got[i] = txd;
        end
        repeat (BIT_CLKS) @(negedge clk);
        check(txd == 1'b1, "R2 stop bit", txd, 1);
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected character", got, 0);
        end else begin
          item = exp_q.pop_front();
          check(got == item[7:0], "R2 data bits", got, item[7:0]);
          if (item[8]) check(gap == BIT_CLKS / 2, "R4 gap before start", gap, BIT_CLKS / 2);
        end
        gap = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    bit ok;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(A_ST, r); check(r == 8'h06, "R1 status after reset", r, 8'h06);
    bus_read(A_EN, r); check(r == 8'h00, "R1 enables after reset", r, 0);
    check(txd == 1'b1 && {irq_rx_full, irq_tx_empty, irq_tx_end} == 3'b000,
          "R1 line and irqs", {txd, irq_rx_full, irq_tx_empty, irq_tx_end}, 4'b1000);

    // R7 enable readback, R3/R5/R6 gating
    bus_write(A_EN, 8'h07);
    bus_read(A_EN, r); check(r == 8'h07, "R7 enable readback", r, 7);
    check(irq_tx_empty == 1'b1, "R3 irq_tx_empty enabled", irq_tx_empty, 1);
    check(irq_tx_end == 1'b1, "R5 irq_tx_end enabled", irq_tx_end, 1);
    check(irq_rx_full == 1'b0, "R6 irq_rx_full idle", irq_rx_full, 0);

    // single byte, flags right after the write edge
    send_tx(8'hA5, 1'b0);
    bus_addr = A_ST;
    #1 r = bus_rdata;
    check(r[1] == 1'b0, "R3 write clears tx_empty", r[1], 0);
    check(r[2] == 1'b0, "R5 write clears tx_end", r[2], 0);
    check(irq_tx_empty == 1'b0, "R3 irq follows flag", irq_tx_empty, 0);
    bus_read(A_ST, r);
    check(r[1] == 1'b1, "R3 refilled on move to shifter", r[1], 1);
    check(r[2] == 1'b0, "R5 no end while shifting", r[2], 0);

    // two more bytes, each waiting behind the shifter
    send_tx(8'h3C, 1'b1);
    wait_status(1, 1'b1, 2000, ok); check(ok, "R3 tx_empty after second move", ok, 1);
    send_tx(8'hC3, 1'b1);
    bus_read(A_ST, r); check(r[2] == 1'b0, "R5 end held off while pending", r[2], 0);
    wait_status(2, 1'b1, 3000, ok); check(ok, "R5 tx_end after last stop", ok, 1);
    check(irq_tx_end == 1'b1 && txd == 1'b1, "R5 irq and idle line", {irq_tx_end, txd}, 2'b11);
    repeat (BIT_CLKS) @(negedge clk);
    check(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);

    // W1C: tx_end clears, tx_empty ignores
    bus_write(A_ST, 8'h06);
    bus_read(A_ST, r);
    check(r[2] == 1'b0, "R5 clear by status write", r[2], 0);
    check(r[1] == 1'b1, "R3 status write leaves tx_empty", r[1], 1);
    check(irq_tx_end == 1'b0, "R5 irq drops", irq_tx_end, 0);

    // receive
    drive_rx(8'h5A, 1'b1);
    bus_read(A_ST, r); check(r[0] == 1'b1, "R6 rx_full set", r[0], 1);
    bus_read(A_RX, r); check(r == 8'h5A, "R6 received data", r, 8'h5A);
    check(irq_rx_full == 1'b1, "R6 irq_rx_full", irq_rx_full, 1);
    bus_write(A_EN, 8'h06);
    check(irq_rx_full == 1'b0, "R6 irq gated by enable", irq_rx_full, 0);
    bus_write(A_EN, 8'h07);
    bus_write(A_ST, 8'h01);
    bus_read(A_ST, r); check(r[0] == 1'b0, "R7 clear rx_full", r[0], 0);
    check(irq_rx_full == 1'b0, "R7 irq drops", irq_rx_full, 0);
    drive_rx(8'h81, 1'b1);
    bus_read(A_RX, r); check(r == 8'h81, "R7 next character taken", r, 8'h81);

    // overrun
    drive_rx(8'hE7, 1'b1);
    bus_read(A_ST, r); check(r[3] == 1'b1 && r[0] == 1'b1, "R8 overrun flag", r, 8'h09);
    bus_read(A_RX, r); check(r == 8'h81, "R8 data kept", r, 8'h81);
    bus_write(A_ST, 8'h09);
    bus_read(A_ST, r); check(r[3] == 1'b0 && r[0] == 1'b0, "R8 flags cleared", r, 0);

    // framing
    drive_rx(8'h44, 1'b0);
    bus_read(A_ST, r); check(r[4] == 1'b1 && r[0] == 1'b0, "R9 framing, no transfer", r, 8'h10);
    bus_read(A_RX, r); check(r == 8'h81, "R9 data untouched", r, 8'h81);
    bus_write(A_ST, 8'h10);
    bus_read(A_ST, r); check(r[4] == 1'b0, "R9 framing cleared", r[4], 0);

    // glitch
    @(negedge clk); rxd = 1'b0;
    repeat (BIT_CLKS / 4) @(negedge clk); rxd = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    bus_read(A_ST, r); check(r[0] == 1'b0 && r[4] == 1'b0, "R10 glitch ignored", r[4:0], 5'h02);
    bus_read(A_RX, r); check(r == 8'h81, "R10 data untouched", r, 8'h81);
    drive_rx(8'h96, 1'b1);
    bus_read(A_RX, r); check(r == 8'h96, "R10 recovers after glitch", r, 8'h96);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule